// File: doc/BRIEF.md
# I/O Range Claim and Conflict-Probe Responder

This block is the I/O-facing part of one logical device on a configurable expansion card. A configuration host programs it with an index, a data byte and a write strobe. It holds three kinds of setting: an enable that puts the device on the bus, a probe control, and up to eight 16-bit I/O base addresses. Each base address opens a window of `RANGE_LEN` consecutive ports.

The block watches every bus I/O read. When the device is enabled and the read address falls in one of its windows, the block claims the read and returns the byte offered by the device function on `devData`. When the device is disabled but the probe is armed, a read inside a window returns a fixed pattern instead. Software uses this pattern to find address conflicts before it enables the device. A configuration-control device reset returns every setting to zero.

Top module: `ioRangeResponder`

## Requirements
- R1: After `rstN` is low, `hit` and `rdData` are 0 and every configuration index reads back 0.
- R2: A write to index 0x30 stores bit 0 as the device enable. Index 0x30 reads back that bit in bit 0 and 0 in bits [7:1].
- R3: A write to index 0x31 stores bit 1 as the probe enable and bit 0 as the pattern select. Index 0x31 reads back those two bits in [1:0] and 0 in bits [7:2].
- R4: Range n (0..7) takes base bits [15:8] at index 0x60+2n and base bits [7:0] at index 0x61+2n. Both indices read back the stored byte.
- R5: When the device is enabled, an I/O read at an address in [base, base+RANGE_LEN-1] of any range sets `hit` and drives `devData` on `rdData` in the next cycle.
- R6: When the device is disabled and the probe is enabled, a read inside a window gives `hit` and `rdData`=0x55 in the next cycle if the pattern select is 1. It gives 0xAA if the pattern select is 0.
- R7: A read outside every window gives no hit. A range whose base is 0 is unused and matches nothing. With the device disabled and the probe off, reads give no hit.
- R8: Writing 1 to the device enable clears the probe enable. A probe-enable write made while the device is enabled stores 0, so the two are never on together.
- R9: A pulse on `devReset` clears the device enable, the probe control and all base registers to 0.
- R10: `rdData` is 0 in every cycle in which `hit` is low.
- R11: Writes to indices other than 0x30, 0x31 and 0x60..0x6F change no stored setting, and those indices read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgIndex | input | 8 | Configuration register index (write and readback) |
| cfgWrData | input | 8 | Configuration write byte |
| cfgRdData | output | 8 | Readback of the register at `cfgIndex` (combinational) |
| devReset | input | 1 | Configuration-control device reset pulse |
| ioRdEn | input | 1 | Bus I/O read qualifier |
| ioAddr | input | 16 | Bus I/O read address |
| devData | input | 8 | Byte returned by the device function on a claimed read |
| hit | output | 1 | Read claimed, registered |
| rdData | output | 8 | Read byte, registered, 0 unless `hit` |

## Verification
An I/O read presented in cycle N has its `hit` and `rdData` result registered at that edge. The result is sampled at the following falling edge. A configuration write takes effect at the edge where it is strobed. Readback through `cfgRdData` is combinational, so it is checked shortly after the index changes. The driver queues the expected result of each read. The monitor pops it only in the cycle after a read was seen at an edge, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/ioRangePkg.sv
package ioRangePkg;
  localparam int NUM_RANGES  = 8;
  localparam int RANGE_SEL_W = $clog2(NUM_RANGES);
  localparam logic [7:0] IDX_ACT  = 8'h30;
  localparam logic [7:0] IDX_CHK  = 8'h31;
  localparam logic [7:0] IDX_BASE = 8'h60;
  localparam logic [7:0] PAT_ONE  = 8'h55;
  localparam logic [7:0] PAT_ZERO = 8'hAA;

  typedef struct packed {
    logic                   wrAct;
    logic                   wrChk;
    logic                   wrBaseHi;
    logic                   wrBaseLo;
    logic [RANGE_SEL_W-1:0] rangeSel;
    logic                   clrAll;
  } cfgStrobeT;
endpackage

// File: rtl/ioRangeCtrl.sv
module ioRangeCtrl
  import ioRangePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgIndex,
  input  logic       devReset,
  output cfgStrobeT  strb
);
  localparam logic [7:0] BASE_SPAN = 8'(2 * NUM_RANGES);

  logic [7:0] baseOfs;
  logic       inBase;

  assign baseOfs = cfgIndex - IDX_BASE;
  assign inBase  = (cfgIndex >= IDX_BASE) && (baseOfs < BASE_SPAN);

  always_comb begin
    strb          = '0;
    strb.clrAll   = devReset;
    strb.rangeSel = baseOfs[RANGE_SEL_W:1];
    if (cfgWrEn && !devReset) begin
      strb.wrAct    = (cfgIndex == IDX_ACT);
      strb.wrChk    = (cfgIndex == IDX_CHK);
      strb.wrBaseHi = inBase && !baseOfs[0];
      strb.wrBaseLo = inBase &&  baseOfs[0];
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrAct, strb.wrChk, strb.wrBaseHi, strb.wrBaseLo})); // R11
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    devReset |-> !(strb.wrAct || strb.wrChk || strb.wrBaseHi || strb.wrBaseLo)); // R9
endmodule

// File: rtl/ioRangeDatapath.sv
module ioRangeDatapath
  import ioRangePkg::*;
#(
  parameter int RANGE_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobeT   strb,
  input  logic [7:0]  cfgIndex,
  input  logic [7:0]  cfgWrData,
  output logic [7:0]  cfgRdData,
  input  logic        ioRdEn,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  devData,
  output logic        hit,
  output logic [7:0]  rdData
);
  localparam logic [16:0] LEN17 = 17'(RANGE_LEN);

  logic                  actReg;
  logic                  chkEn;
  logic                  chkPat;
  logic [15:0]           baseReg [NUM_RANGES];
  logic [NUM_RANGES-1:0] inRange;
  logic                  anyIn;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      actReg <= 1'b0;
      chkEn  <= 1'b0;
      chkPat <= 1'b0;
      for (int i = 0; i < NUM_RANGES; i++) baseReg[i] <= '0;
    end else begin
      if (strb.wrAct) begin
        actReg <= cfgWrData[0];
        if (cfgWrData[0]) chkEn <= 1'b0;
      end
      if (strb.wrChk) begin
        chkEn  <= cfgWrData[1] & ~actReg;
        chkPat <= cfgWrData[0];
      end
      if (strb.wrBaseHi) baseReg[strb.rangeSel][15:8] <= cfgWrData;
      if (strb.wrBaseLo) baseReg[strb.rangeSel][7:0]  <= cfgWrData;
    end
  end

  generate
    for (genvar g = 0; g < NUM_RANGES; g++) begin : gMatch
      logic [16:0] lo17;
      assign lo17 = {1'b0, baseReg[g]};
      assign inRange[g] = (baseReg[g] != '0) &&
                          ({1'b0, ioAddr} >= lo17) &&
                          ({1'b0, ioAddr} <  lo17 + LEN17);
    end
  endgenerate

  assign anyIn = |inRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit    <= 1'b0;
      rdData <= '0;
    end else if (ioRdEn && anyIn && actReg) begin
      hit    <= 1'b1;
      rdData <= devData;
    end else if (ioRdEn && anyIn && chkEn) begin
      hit    <= 1'b1;
      rdData <= chkPat ? PAT_ONE : PAT_ZERO;
    end else begin
      hit    <= 1'b0;
      rdData <= '0;
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (cfgIndex == IDX_ACT)      cfgRdData = {7'b0, actReg};
    else if (cfgIndex == IDX_CHK) cfgRdData = {6'b0, chkEn, chkPat};
    else begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        if (cfgIndex == IDX_BASE + 8'(2 * i))     cfgRdData = baseReg[i][15:8];
        if (cfgIndex == IDX_BASE + 8'(2 * i + 1)) cfgRdData = baseReg[i][7:0];
      end
    end
  end

  AST_ACT_EXCLUDES_CHK: assert property (@(posedge clk) disable iff (!rstN)
    !(actReg && chkEn)); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> rdData == 8'h00); // R10
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !ioRdEn |=> !hit); // R7
  AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> !actReg && !chkEn && !chkPat); // R9
  AST_PROBE_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    hit && !$past(actReg) |-> (rdData == PAT_ONE || rdData == PAT_ZERO)); // R6
endmodule

// File: rtl/ioRangeResponder.sv
module ioRangeResponder
  import ioRangePkg::*;
#(
  parameter int RANGE_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgIndex,
  input  logic [7:0]  cfgWrData,
  output logic [7:0]  cfgRdData,
  input  logic        devReset,
  input  logic        ioRdEn,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  devData,
  output logic        hit,
  output logic [7:0]  rdData
);
  cfgStrobeT strb;

  ioRangeCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIndex(cfgIndex),
    .devReset(devReset), .strb(strb)
  );

  ioRangeDatapath #(.RANGE_LEN(RANGE_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgIndex(cfgIndex),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .ioRdEn(ioRdEn),
    .ioAddr(ioAddr), .devData(devData), .hit(hit), .rdData(rdData)
  );
endmodule

// File: tb/test_ioRangeResponder.sv
module test_ioRangeResponder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgIndex = '0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        devReset = 1'b0;
  logic        ioRdEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  devData = 8'hC3;
  logic        hit;
  logic [7:0]  rdData;

  int total = 0;
  int bad = 0;
  logic [8:0] expQ[$];
  string      tagQ[$];
  logic       sawRd = 1'b0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  ioRangeResponder #(.RANGE_LEN(8)) i_ioRangeResponder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIndex(cfgIndex),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .devReset(devReset),
    .ioRdEn(ioRdEn), .ioAddr(ioAddr), .devData(devData), .hit(hit),
    .rdData(rdData)
  );

  always @(posedge clk) sawRd <= ioRdEn;

  always @(negedge clk) begin
    if (sawRd && expQ.size() > 0) begin
      logic [8:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if ({hit, rdData} !== e) begin
        bad++;
        $display("FAIL %s: hit/data actual=%b/%02h expected=%b/%02h",
                 t, hit, rdData, e[8], e[7:0]);
      end
    end
  end

  task automatic cfgWrite(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIndex = idx; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgCheck(input logic [7:0] idx, input logic [7:0] e, input string t);
    @(negedge clk);
    cfgIndex = idx;
    #1;
    total++;
    if (cfgRdData !== e) begin
      bad++;
      $display("FAIL %s: index %02h actual=%02h expected=%02h", t, idx, cfgRdData, e);
    end
  endtask

  task automatic ioRead(input logic [15:0] a, input logic eh, input logic [7:0] ed, input string t);
    @(negedge clk);
    ioRdEn = 1'b1; ioAddr = a;
    expQ.push_back({eh, ed});
    tagQ.push_back(t);
    @(negedge clk);
    ioRdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (hit !== 1'b0 || rdData !== 8'h00) begin
      bad++;
      $display("FAIL R1: hit/data actual=%b/%02h expected=0/00", hit, rdData);
    end
    cfgCheck(8'h30, 8'h00, "R1");
    cfgCheck(8'h31, 8'h00, "R1");
    cfgCheck(8'h6F, 8'h00, "R1");

    cfgWrite(8'h30, 8'hFF);
    cfgCheck(8'h30, 8'h01, "R2");
    cfgWrite(8'h30, 8'h00);
    cfgCheck(8'h30, 8'h00, "R2");
    cfgWrite(8'h31, 8'hFF);
    cfgCheck(8'h31, 8'h03, "R3");

    cfgWrite(8'h60, 8'h02); cfgWrite(8'h61, 8'h20);
    cfgWrite(8'h66, 8'h03); cfgWrite(8'h67, 8'h40);
    cfgCheck(8'h60, 8'h02, "R4");
    cfgCheck(8'h61, 8'h20, "R4");
    cfgCheck(8'h66, 8'h03, "R4");
    cfgCheck(8'h67, 8'h40, "R4");

    ioRead(16'h0220, 1'b1, 8'h55, "R6");
    ioRead(16'h0227, 1'b1, 8'h55, "R6");
    ioRead(16'h0228, 1'b0, 8'h00, "R7");
    ioRead(16'h021F, 1'b0, 8'h00, "R7");
    cfgWrite(8'h31, 8'h02);
    ioRead(16'h0344, 1'b1, 8'hAA, "R6");
    ioRead(16'h0005, 1'b0, 8'h00, "R7");
    cfgWrite(8'h31, 8'h00);
    ioRead(16'h0220, 1'b0, 8'h00, "R7");

    cfgWrite(8'h31, 8'h03);
    cfgWrite(8'h30, 8'h01);
    cfgCheck(8'h31, 8'h01, "R8");
    ioRead(16'h0222, 1'b1, 8'hC3, "R5");
    devData = 8'h3C;
    ioRead(16'h0347, 1'b1, 8'h3C, "R5");
    ioRead(16'h0348, 1'b0, 8'h00, "R10");
    cfgWrite(8'h31, 8'h02);
    cfgCheck(8'h31, 8'h00, "R8");

    cfgWrite(8'h32, 8'hFF);
    cfgWrite(8'h70, 8'hFF);
    cfgCheck(8'h30, 8'h01, "R11");
    cfgCheck(8'h31, 8'h00, "R11");
    cfgCheck(8'h32, 8'h00, "R11");
    cfgCheck(8'h60, 8'h02, "R11");

    @(negedge clk); devReset = 1'b1;
    @(negedge clk); devReset = 1'b0;
    cfgCheck(8'h30, 8'h00, "R9");
    cfgCheck(8'h67, 8'h00, "R9");
    ioRead(16'h0222, 1'b0, 8'h00, "R9");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule